// File: doc/BRIEF.md
# Clock Source Mode Controller

This block is the digital control core of a differential clock source for a high-speed memory bus. It turns two active-low board controls (power-down and output stop) and two three-bit select buses (operating mode and PLL multiplier) into an operating state, a choice of which clock drives the output pair, the drive condition of that pair (clocking, grounded or released to high impedance), the feedback and prescaler divider values for the PLL, and timing flags that tell the rest of the system when the output may be trusted.

The clocks being routed (the phase-aligned clock, the raw PLL clock and the reference clock) arrive as plain data inputs and are sampled by the control clock into registered outputs. The analog loop, the phase aligner and the output buffers sit outside. Every select and control input passes through a two-flop synchronizer first. Timing windows that a real part measures in milliseconds or nanoseconds are counted here as parameterised control-clock cycles.

Top module: `clksrc_mode_ctrl`

## Requirements
- R1: `op_state` encodes Power-Down as 2'b00, Clock-Stop as 2'b01 and Run as 2'b10. `pwrdn_n` low gives Power-Down whatever `stop_n` is; `pwrdn_n` high with `stop_n` low gives Clock-Stop; both high gives Run. A change on an input shows on `op_state` at the third rising clock edge after it, and not at the second.
- R2: One edge after `op_state` is Power-Down, the pair is grounded: `drv_en`=1, `clk_p`=0, `clk_n`=0, `src_sel`=0.
- R3: One edge after `op_state` is Clock-Stop, the pair is released: `drv_en`=0 with `clk_p`=`clk_n`=0.
- R4: In Run, `mode_sel` (bit 0 first select bit, bit 1 second, bit 2 third) picks the source: 3'b000 the phase-aligned clock (`src_sel`=1), 3'b001 the PLL clock (`src_sel`=2), 3'b011 the reference clock (`src_sel`=3). The pair is then driven with `clk_p` equal to the source sampled at that edge and `clk_n` its inverse, one edge after `op_state` enters Run.
- R5: In Run, `mode_sel` 3'b010 and 3'b110 release the pair (`drv_en`=0, `src_sel`=0); 3'b100, 3'b101 and 3'b111 drive both legs low (`drv_en`=1, `src_sel`=0, `clk_p`=`clk_n`=0).
- R6: `mode_sel` is captured only while the synchronized power-down input is low; a change while not in Power-Down leaves `src_sel` and the drive unchanged.
- R7: `mult_sel` maps to feedback divider `fb_div` and prescaler `pre_div`: 3'b000 gives 4/1, 3'b001 gives 9/2, 3'b010 gives 6/1, 3'b100 gives 8/3, 3'b101 gives 16/3, 3'b110 gives 8/1, visible three edges after the input change.
- R8: `mult_sel` 3'b011 and 3'b111 raise `cfg_invalid`, and `fb_div`/`pre_div` keep the last valid pair while it is raised.
- R9: Any `mult_sel` change drops `mult_ready` on the edge the new dividers appear; it rises again exactly MULT_SETTLE_CYC edges later if no further change occurs.
- R10: `mult_ready` is low in Power-Down and rises PWRUP_SETTLE_CYC edges after the last edge that still saw power-down asserted through the synchronizer (eleven edges after `op_state` leaves Power-Down with a setting of 12).
- R11: `out_glitchfree` is low when `op_state` enters Run and rises GLITCH_CYC edges later.
- R12: `phase_settled` is low on entry to Run and rises PHASE_CYC edges after entry; it is never high without `out_glitchfree`.
- R13: After synchronous reset: Power-Down, pair grounded, `src_sel`=0, `fb_div`=4, `pre_div`=1, `cfg_invalid`=0 and all three flags low.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Control clock |
| rst | input | 1 | Synchronous active-high reset |
| pwrdn_n | input | 1 | Active-low power-down request |
| stop_n | input | 1 | Active-low output stop request |
| mode_sel | input | 3 | Operating mode select |
| mult_sel | input | 3 | PLL multiplier select |
| pa_clk | input | 1 | Phase-aligned clock level |
| pll_clk | input | 1 | Raw PLL clock level |
| ref_clk | input | 1 | Reference clock level |
| op_state | output | 2 | Operating state |
| src_sel | output | 2 | Driven source: 0 none, 1 aligned, 2 PLL, 3 reference |
| clk_p | output | 1 | True output leg |
| clk_n | output | 1 | Complement output leg |
| drv_en | output | 1 | 1 drives the pair, 0 releases it to high impedance |
| fb_div | output | 5 | Decoded feedback divider |
| pre_div | output | 2 | Decoded prescaler divider |
| cfg_invalid | output | 1 | Multiplier select has no mapping |
| mult_ready | output | 1 | PLL settle time elapsed |
| out_glitchfree | output | 1 | Past the enable glitch window |
| phase_settled | output | 1 | Output phase settled |

## Verification
A wrong state register shows one edge later on the drive pins: a grounded pair where a released one belongs, or the reverse, or a source on `src_sel` that differs from the one captured in the last power-down. A mode register that was reloaded outside Power-Down shows as a changed `src_sel` within four edges of the offending input, so the bench changes `mode_sel` in Run and Clock-Stop and watches it stay put. Counter faults show as a ready or settle flag rising one edge early or late, so every timing flag is sampled on both sides of its expected rising edge.

// File: rtl/clksrc_pkg.sv
package clksrc_pkg;

  localparam int FB_W  = 5;
  localparam int PRE_W = 2;

  typedef enum logic [1:0] {
    ST_PDN  = 2'b00,
    ST_STOP = 2'b01,
    ST_RUN  = 2'b10
  } op_state_e;

  typedef enum logic [1:0] {
    SRC_NONE = 2'd0,
    SRC_PA   = 2'd1,
    SRC_PLL  = 2'd2,
    SRC_REF  = 2'd3
  } src_e;

  typedef struct packed {
    src_e src;
    logic drive;
  } mode_dec_t;

  typedef struct packed {
    logic             valid;
    logic [FB_W-1:0]  fb;
    logic [PRE_W-1:0] pre;
  } mult_dec_t;

  // bit0/bit1/bit2 are the first/second/third select bits
  function automatic mode_dec_t decode_mode(input logic [2:0] m);
    mode_dec_t d;
    d.src   = SRC_NONE;
    d.drive = 1'b1;
    case (m)
      3'b000:         d.src = SRC_PA;
      3'b001:         d.src = SRC_PLL;
      3'b011:         d.src = SRC_REF;
      3'b010, 3'b110: d.drive = 1'b0;
      default:        d.src = SRC_NONE;
    endcase
    return d;
  endfunction

  function automatic mult_dec_t decode_mult(input logic [2:0] m);
    mult_dec_t d;
    d.valid = 1'b1;
    d.fb    = FB_W'(4);
    d.pre   = PRE_W'(1);
    case (m)
      3'b000: begin d.fb = FB_W'(4);  d.pre = PRE_W'(1); end
      3'b001: begin d.fb = FB_W'(9);  d.pre = PRE_W'(2); end
      3'b010: begin d.fb = FB_W'(6);  d.pre = PRE_W'(1); end
      3'b100: begin d.fb = FB_W'(8);  d.pre = PRE_W'(3); end
      3'b101: begin d.fb = FB_W'(16); d.pre = PRE_W'(3); end
      3'b110: begin d.fb = FB_W'(8);  d.pre = PRE_W'(1); end
      default: d.valid = 1'b0;
    endcase
    return d;
  endfunction

endpackage

// File: rtl/clksrc_sync.sv
module clksrc_sync #(
  parameter int W      = 1,
  parameter int STAGES = 2
) (
  input  logic         clk,
  input  logic         rst,
  input  logic [W-1:0] d,
  output logic [W-1:0] q
);

  for (genvar g = 0; g < STAGES; g++) begin : g_st
    logic [W-1:0] r;
    if (g == 0) begin : g_first
      always_ff @(posedge clk) begin
        if (rst) r <= '0;
        else     r <= d;
      end
    end else begin : g_next
      always_ff @(posedge clk) begin
        if (rst) r <= '0;
        else     r <= g_st[g-1].r;
      end
    end
  end

  assign q = g_st[STAGES-1].r;

endmodule

// File: rtl/clksrc_state_ctrl.sv
module clksrc_state_ctrl
  import clksrc_pkg::*;
#(
  parameter int GLITCH_CYC = 3,
  parameter int PHASE_CYC  = 20
) (
  input  logic       clk,
  input  logic       rst,
  input  logic       pd_n_s,
  input  logic       stop_n_s,
  input  logic [2:0] mode_s,
  output op_state_e  state,
  output logic [2:0] mode_q,
  output logic       glitchfree,
  output logic       settled
);

  localparam int PW = $clog2(PHASE_CYC + 1);

  op_state_e       st_next;
  logic [PW-1:0]   cnt, cnt_next;

  always_comb begin
    if (!pd_n_s)        st_next = ST_PDN;
    else if (!stop_n_s) st_next = ST_STOP;
    else                st_next = ST_RUN;

    if (st_next != ST_RUN || state != ST_RUN) cnt_next = '0;
    else if (cnt == PW'(PHASE_CYC))           cnt_next = cnt;
    else                                      cnt_next = cnt + 1'b1;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      state      <= ST_PDN;
      mode_q     <= 3'b000;
      cnt        <= '0;
      glitchfree <= 1'b0;
      settled    <= 1'b0;
    end else begin
      state      <= st_next;
      if (!pd_n_s) mode_q <= mode_s;
      cnt        <= cnt_next;
      glitchfree <= (st_next == ST_RUN) && (cnt_next >= PW'(GLITCH_CYC));
      settled    <= (st_next == ST_RUN) && (cnt_next >= PW'(PHASE_CYC));
    end
  end

endmodule

// File: rtl/clksrc_mult_ctrl.sv
module clksrc_mult_ctrl
  import clksrc_pkg::*;
#(
  parameter int PWRUP_SETTLE_CYC = 750000,
  parameter int MULT_SETTLE_CYC  = 250000
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             pd_n_s,
  input  logic [2:0]       mult_s,
  output logic [FB_W-1:0]  fb_div,
  output logic [PRE_W-1:0] pre_div,
  output logic             invalid,
  output logic             ready
);

  localparam int MAXC = (PWRUP_SETTLE_CYC > MULT_SETTLE_CYC) ? PWRUP_SETTLE_CYC : MULT_SETTLE_CYC;
  localparam int CW   = $clog2(MAXC + 1);

  mult_dec_t     dec;
  logic [2:0]    prev;
  logic [CW-1:0] cnt, cnt_next;
  logic          load;

  always_comb begin
    dec  = decode_mult(mult_s);
    load = !pd_n_s || (mult_s != prev);
    if (!pd_n_s)        cnt_next = CW'(PWRUP_SETTLE_CYC);
    else if (load)      cnt_next = CW'(MULT_SETTLE_CYC);
    else if (cnt != '0) cnt_next = cnt - 1'b1;
    else                cnt_next = cnt;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      prev    <= 3'b000;
      cnt     <= CW'(PWRUP_SETTLE_CYC);
      ready   <= 1'b0;
      fb_div  <= FB_W'(4);
      pre_div <= PRE_W'(1);
      invalid <= 1'b0;
    end else begin
      prev    <= mult_s;
      cnt     <= cnt_next;
      ready   <= !load && (cnt_next == '0);
      invalid <= !dec.valid;
      if (dec.valid) begin
        fb_div  <= dec.fb;
        pre_div <= dec.pre;
      end
    end
  end

endmodule

// File: rtl/clksrc_out_drv.sv
module clksrc_out_drv
  import clksrc_pkg::*;
(
  input  logic       clk,
  input  logic       rst,
  input  op_state_e  state,
  input  logic [2:0] mode_q,
  input  logic       pa_clk,
  input  logic       pll_clk,
  input  logic       ref_clk,
  output logic       clk_p,
  output logic       clk_n,
  output logic       drv_en,
  output src_e       src_sel
);

  mode_dec_t md;
  logic      lvl;

  always_comb begin
    md = decode_mode(mode_q);
    case (md.src)
      SRC_PA:  lvl = pa_clk;
      SRC_PLL: lvl = pll_clk;
      SRC_REF: lvl = ref_clk;
      default: lvl = 1'b0;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      clk_p   <= 1'b0;
      clk_n   <= 1'b0;
      drv_en  <= 1'b1;
      src_sel <= SRC_NONE;
    end else begin
      case (state)
        ST_RUN: begin
          drv_en  <= md.drive;
          src_sel <= md.drive ? md.src : SRC_NONE;
          if (md.drive && md.src != SRC_NONE) begin
            clk_p <= lvl;
            clk_n <= ~lvl;
          end else begin
            clk_p <= 1'b0;
            clk_n <= 1'b0;
          end
        end
        ST_STOP: begin
          drv_en  <= 1'b0;
          src_sel <= SRC_NONE;
          clk_p   <= 1'b0;
          clk_n   <= 1'b0;
        end
        default: begin
          drv_en  <= 1'b1;
          src_sel <= SRC_NONE;
          clk_p   <= 1'b0;
          clk_n   <= 1'b0;
        end
      endcase
    end
  end

endmodule

// File: rtl/clksrc_mode_ctrl.sv
module clksrc_mode_ctrl
  import clksrc_pkg::*;
#(
  parameter int SYNC_STAGES      = 2,
  parameter int PWRUP_SETTLE_CYC = 750000,
  parameter int MULT_SETTLE_CYC  = 250000,
  parameter int GLITCH_CYC       = 3,
  parameter int PHASE_CYC        = 20
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             pwrdn_n,
  input  logic             stop_n,
  input  logic [2:0]       mode_sel,
  input  logic [2:0]       mult_sel,
  input  logic             pa_clk,
  input  logic             pll_clk,
  input  logic             ref_clk,
  output logic [1:0]       op_state,
  output logic [1:0]       src_sel,
  output logic             clk_p,
  output logic             clk_n,
  output logic             drv_en,
  output logic [FB_W-1:0]  fb_div,
  output logic [PRE_W-1:0] pre_div,
  output logic             cfg_invalid,
  output logic             mult_ready,
  output logic             out_glitchfree,
  output logic             phase_settled
);

  localparam int CTL_W = 8;

  logic [CTL_W-1:0] ctl_raw, ctl_s;
  logic             pd_n_s, stop_n_s;
  logic [2:0]       mode_s, mult_s;
  logic [2:0]       mode_cur;
  op_state_e        state;
  src_e             src;

  assign ctl_raw  = {mult_sel, mode_sel, stop_n, pwrdn_n};
  assign pd_n_s   = ctl_s[0];
  assign stop_n_s = ctl_s[1];
  assign mode_s   = ctl_s[4:2];
  assign mult_s   = ctl_s[7:5];

  clksrc_sync #(.W(CTL_W), .STAGES(SYNC_STAGES)) u_sync (
    .clk (clk),
    .rst (rst),
    .d   (ctl_raw),
    .q   (ctl_s)
  );

  clksrc_state_ctrl #(.GLITCH_CYC(GLITCH_CYC), .PHASE_CYC(PHASE_CYC)) u_state (
    .clk        (clk),
    .rst        (rst),
    .pd_n_s     (pd_n_s),
    .stop_n_s   (stop_n_s),
    .mode_s     (mode_s),
    .state      (state),
    .mode_q     (mode_cur),
    .glitchfree (out_glitchfree),
    .settled    (phase_settled)
  );

  clksrc_mult_ctrl #(
    .PWRUP_SETTLE_CYC (PWRUP_SETTLE_CYC),
    .MULT_SETTLE_CYC  (MULT_SETTLE_CYC)
  ) u_mult (
    .clk     (clk),
    .rst     (rst),
    .pd_n_s  (pd_n_s),
    .mult_s  (mult_s),
    .fb_div  (fb_div),
    .pre_div (pre_div),
    .invalid (cfg_invalid),
    .ready   (mult_ready)
  );

  clksrc_out_drv u_out (
    .clk     (clk),
    .rst     (rst),
    .state   (state),
    .mode_q  (mode_cur),
    .pa_clk  (pa_clk),
    .pll_clk (pll_clk),
    .ref_clk (ref_clk),
    .clk_p   (clk_p),
    .clk_n   (clk_n),
    .drv_en  (drv_en),
    .src_sel (src)
  );

  assign op_state = state;
  assign src_sel  = src;

endmodule

// File: rtl/clksrc_mode_ctrl_chk.sv
module clksrc_mode_ctrl_chk
  import clksrc_pkg::*;
(
  input logic             clk,
  input logic             rst,
  input logic [1:0]       op_state,
  input logic [1:0]       src_sel,
  input logic             clk_p,
  input logic             clk_n,
  input logic             drv_en,
  input logic [FB_W-1:0]  fb_div,
  input logic [PRE_W-1:0] pre_div,
  input logic             cfg_invalid,
  input logic             mult_ready,
  input logic             out_glitchfree,
  input logic             phase_settled,
  input logic [2:0]       mode_cur
);

  assert_pdn_ground_R2: assert property (@(posedge clk) disable iff (rst)
    (op_state == ST_PDN) |=> (drv_en && !clk_p && !clk_n));

  assert_stop_release_R3: assert property (@(posedge clk) disable iff (rst)
    (op_state == ST_STOP) |=> !drv_en);

  assert_complement_R4: assert property (@(posedge clk) disable iff (rst)
    (drv_en && src_sel != SRC_NONE) |-> (clk_n == !clk_p));

  assert_mode_hold_R6: assert property (@(posedge clk) disable iff (rst)
    (op_state != ST_PDN) |-> $stable(mode_cur));

  assert_div_hold_R8: assert property (@(posedge clk) disable iff (rst)
    cfg_invalid |-> ($stable(fb_div) && $stable(pre_div)));

  assert_ready_restart_R9: assert property (@(posedge clk) disable iff (rst)
    !$stable(fb_div) |-> !mult_ready);

  assert_no_ready_pdn_R10: assert property (@(posedge clk) disable iff (rst)
    (op_state == ST_PDN) |-> !mult_ready);

  assert_settle_order_R12: assert property (@(posedge clk) disable iff (rst)
    phase_settled |-> (out_glitchfree && op_state == ST_RUN));

endmodule

bind clksrc_mode_ctrl clksrc_mode_ctrl_chk u_chk (
  .clk            (clk),
  .rst            (rst),
  .op_state       (op_state),
  .src_sel        (src_sel),
  .clk_p          (clk_p),
  .clk_n          (clk_n),
  .drv_en         (drv_en),
  .fb_div         (fb_div),
  .pre_div        (pre_div),
  .cfg_invalid    (cfg_invalid),
  .mult_ready     (mult_ready),
  .out_glitchfree (out_glitchfree),
  .phase_settled  (phase_settled),
  .mode_cur       (mode_cur)
);

// File: tb/clksrc_mode_ctrl_tb.sv
module clksrc_mode_ctrl_tb;

  localparam int S_STATE = 0, S_EN = 1, S_P = 2, S_N = 3, S_SRC = 4, S_FB = 5,
                 S_PRE = 6, S_INV = 7, S_RDY = 8, S_GF = 9, S_PS = 10;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic pwrdn_n = 1'b0, stop_n = 1'b0;
  logic [2:0] mode_sel = 3'b000, mult_sel = 3'b000;
  logic pa_clk = 1'b0, pll_clk = 1'b0, ref_clk = 1'b0;
  logic [1:0] op_state, src_sel;
  logic clk_p, clk_n, drv_en, cfg_invalid, mult_ready, out_glitchfree, phase_settled;
  logic [4:0] fb_div;
  logic [1:0] pre_div;

  int cyc = 0;
  int checks = 0;
  int errors = 0;
  bit done = 1'b0;
  logic [2:0] cur_mult = 3'b000;

  typedef struct {
    int    due;
    int    sig;
    int    val;
    string req;
  } exp_t;
  exp_t sb[$];

  always #2 clk = ~clk;

  clksrc_mode_ctrl #(
    .PWRUP_SETTLE_CYC (12),
    .MULT_SETTLE_CYC  (8),
    .GLITCH_CYC       (3),
    .PHASE_CYC        (20)
  ) u_dut (
    .clk(clk), .rst(rst), .pwrdn_n(pwrdn_n), .stop_n(stop_n),
    .mode_sel(mode_sel), .mult_sel(mult_sel),
    .pa_clk(pa_clk), .pll_clk(pll_clk), .ref_clk(ref_clk),
    .op_state(op_state), .src_sel(src_sel), .clk_p(clk_p), .clk_n(clk_n),
    .drv_en(drv_en), .fb_div(fb_div), .pre_div(pre_div),
    .cfg_invalid(cfg_invalid), .mult_ready(mult_ready),
    .out_glitchfree(out_glitchfree), .phase_settled(phase_settled)
  );

  always @(posedge clk) cyc <= cyc + 1;

  function automatic int sample(input int sig);
    case (sig)
      S_STATE: return int'(op_state);
      S_EN:    return int'(drv_en);
      S_P:     return int'(clk_p);
      S_N:     return int'(clk_n);
      S_SRC:   return int'(src_sel);
      S_FB:    return int'(fb_div);
      S_PRE:   return int'(pre_div);
      S_INV:   return int'(cfg_invalid);
      S_RDY:   return int'(mult_ready);
      S_GF:    return int'(out_glitchfree);
      default: return int'(phase_settled);
    endcase
  endfunction

  // monitor: compares every expected item that falls due on this half cycle
  always @(negedge clk) begin
    for (int i = sb.size() - 1; i >= 0; i--) begin
      if (sb[i].due == cyc) begin
        int act;
        act = sample(sb[i].sig);
        checks++;
        if (act != sb[i].val) begin
          errors++;
          $display("FAIL %s: signal %0d at cycle %0d actual %0d expected %0d",
                   sb[i].req, sb[i].sig, cyc, act, sb[i].val);
        end
        sb.delete(i);
      end
    end
  end

  task automatic expect_at(input int d, input int sig, input int val, input string req);
    exp_t e;
    e.due = cyc + d;
    e.sig = sig;
    e.val = val;
    e.req = req;
    sb.push_back(e);
  endtask

  task automatic idle(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic drive(input logic pd, input logic st, input logic [2:0] md, input logic [2:0] ml);
    @(negedge clk);
    pwrdn_n  = pd;
    stop_n   = st;
    mode_sel = md;
    mult_sel = ml;
    cur_mult = ml;
  endtask

  task automatic mult_check(input logic [2:0] code, input int fb, input int pre, input int inv, input string req);
    drive(1'b1, 1'b1, mode_sel, code);
    expect_at(3, S_FB, fb, req);
    expect_at(3, S_PRE, pre, req);
    expect_at(3, S_INV, inv, req);
    idle(5);
  endtask

  task automatic run_mode(input logic [2:0] md, input logic a, input logic b, input logic r,
                          input int esrc, input int een, input int ep, input string req);
    drive(1'b0, 1'b1, md, cur_mult);
    idle(4);
    pa_clk = a; pll_clk = b; ref_clk = r;
    drive(1'b1, 1'b1, md, cur_mult);
    expect_at(3, S_STATE, 2, "R1");
    expect_at(4, S_SRC, esrc, req);
    expect_at(4, S_EN, een, req);
    expect_at(4, S_P, ep, req);
    expect_at(4, S_N, (esrc != 0) ? 1 - ep : 0, req);
    idle(8);
  endtask

  initial begin
    // R13: reset values
    idle(3);
    expect_at(1, S_STATE, 0, "R13");
    expect_at(1, S_EN, 1, "R13");
    expect_at(1, S_P, 0, "R13");
    expect_at(1, S_N, 0, "R13");
    expect_at(1, S_SRC, 0, "R13");
    expect_at(1, S_FB, 4, "R13");
    expect_at(1, S_PRE, 1, "R13");
    expect_at(1, S_INV, 0, "R13");
    expect_at(1, S_RDY, 0, "R13");
    expect_at(1, S_GF, 0, "R13");
    expect_at(1, S_PS, 0, "R13");
    @(negedge clk);
    rst = 1'b0;
    idle(5);
    expect_at(1, S_STATE, 0, "R1");
    expect_at(1, S_EN, 1, "R2");
    expect_at(1, S_P, 0, "R2");
    expect_at(1, S_N, 0, "R2");
    idle(2);

    // leave power-down into Run with the aligned clock
    pa_clk = 1'b1;
    drive(1'b1, 1'b1, 3'b000, 3'b000);
    expect_at(2, S_STATE, 0, "R1");
    expect_at(3, S_STATE, 2, "R1");
    expect_at(4, S_SRC, 1, "R4");
    expect_at(4, S_EN, 1, "R4");
    expect_at(4, S_P, 1, "R4");
    expect_at(4, S_N, 0, "R4");
    expect_at(3, S_RDY, 0, "R10");
    expect_at(13, S_RDY, 0, "R10");
    expect_at(14, S_RDY, 1, "R10");
    expect_at(5, S_GF, 0, "R11");
    expect_at(6, S_GF, 1, "R11");
    expect_at(22, S_PS, 0, "R12");
    expect_at(23, S_PS, 1, "R12");
    idle(30);
    @(negedge clk);
    pa_clk = 1'b0;
    expect_at(1, S_P, 0, "R4");
    expect_at(1, S_N, 1, "R4");
    idle(2);

    // multiplier changes in Run
    drive(1'b1, 1'b1, 3'b000, 3'b001);
    expect_at(3, S_FB, 9, "R7");
    expect_at(3, S_PRE, 2, "R7");
    expect_at(3, S_RDY, 0, "R9");
    expect_at(10, S_RDY, 0, "R9");
    expect_at(11, S_RDY, 1, "R9");
    idle(14);
    drive(1'b1, 1'b1, 3'b000, 3'b011);
    expect_at(3, S_INV, 1, "R8");
    expect_at(3, S_FB, 9, "R8");
    expect_at(3, S_PRE, 2, "R8");
    expect_at(6, S_FB, 9, "R8");
    idle(6);
    mult_check(3'b101, 16, 3, 0, "R7");
    mult_check(3'b010, 6, 1, 0, "R7");
    mult_check(3'b100, 8, 3, 0, "R7");
    mult_check(3'b110, 8, 1, 0, "R7");
    mult_check(3'b111, 8, 1, 1, "R8");
    mult_check(3'b000, 4, 1, 0, "R7");
    idle(12);

    // clock stop and return
    drive(1'b1, 1'b0, 3'b000, 3'b000);
    expect_at(3, S_STATE, 1, "R1");
    expect_at(4, S_EN, 0, "R3");
    expect_at(4, S_P, 0, "R3");
    expect_at(4, S_N, 0, "R3");
    expect_at(3, S_GF, 0, "R11");
    expect_at(3, S_PS, 0, "R12");
    idle(6);
    drive(1'b1, 1'b0, 3'b001, 3'b000);
    idle(6);
    drive(1'b1, 1'b1, 3'b001, 3'b000);
    expect_at(3, S_STATE, 2, "R1");
    expect_at(4, S_EN, 1, "R4");
    expect_at(4, S_SRC, 1, "R6");
    expect_at(5, S_GF, 0, "R11");
    expect_at(6, S_GF, 1, "R11");
    expect_at(22, S_PS, 0, "R12");
    expect_at(23, S_PS, 1, "R12");
    idle(26);

    // source selection through power-down capture
    run_mode(3'b001, 1'b0, 1'b1, 1'b0, 2, 1, 1, "R4");
    run_mode(3'b001, 1'b1, 1'b0, 1'b1, 2, 1, 0, "R4");
    drive(1'b1, 1'b1, 3'b011, cur_mult);
    idle(6);
    expect_at(1, S_SRC, 2, "R6");
    idle(2);
    run_mode(3'b011, 1'b0, 1'b0, 1'b1, 3, 1, 1, "R4");
    run_mode(3'b010, 1'b1, 1'b1, 1'b1, 0, 0, 0, "R5");
    run_mode(3'b110, 1'b1, 1'b1, 1'b1, 0, 0, 0, "R5");
    run_mode(3'b100, 1'b1, 1'b1, 1'b1, 0, 1, 0, "R5");
    run_mode(3'b101, 1'b1, 1'b1, 1'b1, 0, 1, 0, "R5");
    run_mode(3'b111, 1'b1, 1'b1, 1'b1, 0, 1, 0, "R5");

    // power-down wins over stop
    drive(1'b0, 1'b0, 3'b000, cur_mult);
    expect_at(3, S_STATE, 0, "R1");
    expect_at(4, S_EN, 1, "R2");
    expect_at(4, S_P, 0, "R2");
    expect_at(3, S_RDY, 0, "R10");
    idle(8);

    done = 1'b1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      errors++;
      $display("FAIL watchdog: actual hung run expected completion");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

endmodule